// File: doc/BRIEF.md
# Modulo Timer with Overflow Flag

This block is a 16-bit up-counter driven from the bus clock through a power-of-two prescaler. Software programs a modulo value; the counter runs from zero up to that value, returns to zero on the following prescaled tick and sets an overflow flag. The flag can raise an interrupt request when enabled.

Software controls the timer through five byte-wide registers on a simple read/write strobe interface. The status/control register holds the flag, interrupt enable, stop bit, counter-reset bit and prescaler select. The counter can be read as two bytes, and the modulo as two writable bytes. The flag is cleared only by a two-step handshake. An overflow that arrives in the middle of that handshake keeps the flag set, so no event is lost. The counter is halted out of reset until software clears the stop bit.

Top module: `modtmr_top`

## Requirements
- R1: After reset the status register (address 0) reads 0x20: flag (bit 7) 0, interrupt enable (bit 6) 0, stop (bit 5) 1, counter reset (bit 4) 0, bit 3 0, prescaler select (bits 2:0) 0. The counter (high byte at address 1, low byte at address 2) reads 0 and stays 0. The modulo (high byte at address 3, low byte at address 4) reads 0xFFFF. The irq output is 0.
- R2: Prescaler select codes 0 to 6 divide the clock by 2^code, and code 7 divides by 64. After a counter reset, K running cycles at divide D leave the counter at floor(K/D) modulo (M+1), where M is the modulo value.
- R3: A tick that finds the counter equal to the modulo value returns the counter to 0 and sets the flag on that same edge. The flag sets at no other time.
- R4: While the stop bit is 1 the counter holds its value. After the stop bit is cleared, counting resumes from the held value.
- R5: Writing the status register with bit 4 = 1 clears the counter and the prescaler on that edge. Bit 4 always reads as 0.
- R6: Writing 0 to bit 7 clears the flag only if the status register was read with the flag set and no status write has happened since that read. Otherwise the flag stays set.
- R7: If an overflow occurs after the arming read and before the clearing write, or on the same edge as that write, the flag stays set.
- R8: Writing 1 to bit 7 leaves the flag unchanged.
- R9: irq is 1 exactly when the flag and the interrupt enable are both 1.
- R10: Reading the counter high byte captures the low byte at that moment. The next low-byte read returns the captured byte. A low-byte read that follows another low-byte read returns the live low byte.
- R11: With a modulo value of 0, the counter stays at 0 and every tick sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address, 0 to 4 |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle (arms the flag handshake and the counter latch) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions check the following on every cycle:
- The counter holds while stopped.
- Every wrap leaves the counter at zero with the flag set.
- The flag rises only after an overflow and falls only after an armed clearing write.
- A counter reset zeroes the count.

Some behaviour only the bench scenarios can show. These are:
- The exact tick count for each prescaler code.
- The reset values.
- The handshake outcomes seen through register reads.
- The high/low read latch.
- The degenerate zero modulo.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 6;
  localparam int SEL_W  = 3;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODH = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODL = 3'd4;

  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_STOP = 5;
  localparam int B_CRST = 4;

  // low-order prescaler bits that must all be 1 for a tick
  function automatic logic [PS_W-1:0] presc_mask(input logic [SEL_W-1:0] sel);
    int lg;
    int m;
    lg = (int'(sel) > PS_W) ? PS_W : int'(sel);
    m  = (1 << lg) - 1;
    return m[PS_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cnt,
                                                  input logic [CNT_W-1:0] modv);
    return (cnt == modv) ? '0 : cnt + 1'b1;
  endfunction
endpackage

// File: rtl/modtmr_presc.sv
module modtmr_presc
  import modtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] mask;

  assign mask = presc_mask(sel);
  assign tick = !stop && ((ps_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) ps_q <= '0;
    else if (!stop)    ps_q <= ps_q + 1'b1;
  end
endmodule

// File: rtl/modtmr_count.sv
module modtmr_count
  import modtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] modv,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt = cnt_q;
  assign ovf = tick && !clr && (cnt_q == modv);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (tick)     cnt_q <= next_count(cnt_q, modv);
  end
endmodule

// File: rtl/modtmr_flag.sv
module modtmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic clr_wr,
  output logic flag,
  output logic arm
);
  logic flag_q;
  logic arm_q;

  assign flag = flag_q;
  assign arm  = arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (ovf) begin
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
    end else if (stat_wr) begin
      if (clr_wr && arm_q) flag_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (stat_rd && flag_q) begin
      arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
  import modtmr_pkg::*;
#(
  parameter logic [CNT_W-1:0] MOD_RST = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int HALF = CNT_W / 2;

  logic             ie_q, stop_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] mod_q;
  logic             lat_v;
  logic [HALF-1:0]  lat_b;

  // named internal events
  logic             tick, ovf_evt, crst_evt, stat_rd, stat_wr, flag_clr_wr;
  logic             flag, arm;
  logic [CNT_W-1:0] cnt;

  assign stat_wr     = reg_wr && (reg_addr == A_CTRL);
  assign stat_rd     = reg_rd && (reg_addr == A_CTRL);
  assign crst_evt    = stat_wr && reg_wdata[B_CRST];
  assign flag_clr_wr = stat_wr && !reg_wdata[B_FLAG];

  modtmr_presc u_presc (
    .clk(clk), .rst_n(rst_n), .stop(stop_q), .clr(crst_evt), .sel(sel_q), .tick(tick)
  );

  modtmr_count u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(crst_evt), .modv(mod_q),
    .cnt(cnt), .ovf(ovf_evt)
  );

  modtmr_flag u_flag (
    .clk(clk), .rst_n(rst_n), .ovf(ovf_evt), .stat_rd(stat_rd), .stat_wr(stat_wr),
    .clr_wr(flag_clr_wr), .flag(flag), .arm(arm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      stop_q <= 1'b1;
      sel_q  <= '0;
      mod_q  <= MOD_RST;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin
          ie_q   <= reg_wdata[B_IE];
          stop_q <= reg_wdata[B_STOP];
          sel_q  <= reg_wdata[SEL_W-1:0];
        end
        A_MODH:  mod_q[CNT_W-1:HALF] <= reg_wdata;
        A_MODL:  mod_q[HALF-1:0]     <= reg_wdata;
        default: ;
      endcase
    end
  end

  // high-byte read captures the low byte for a consistent pair
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_v <= 1'b0;
      lat_b <= '0;
    end else if (reg_rd && reg_addr == A_CNTH) begin
      lat_v <= 1'b1;
      lat_b <= cnt[HALF-1:0];
    end else if (reg_rd && reg_addr == A_CNTL) begin
      lat_v <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {flag, ie_q, stop_q, 1'b0, 1'b0, sel_q};
      A_CNTH:  reg_rdata = cnt[CNT_W-1:HALF];
      A_CNTL:  reg_rdata = lat_v ? lat_b : cnt[HALF-1:0];
      A_MODH:  reg_rdata = mod_q[CNT_W-1:HALF];
      A_MODL:  reg_rdata = mod_q[HALF-1:0];
      default: reg_rdata = '0;
    endcase
  end

  assign irq = flag && ie_q;
endmodule

// File: rtl/modtmr_chk.sv
module modtmr_chk
  import modtmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ovf_evt,
  input logic             crst_evt,
  input logic             flag_clr_wr,
  input logic             flag,
  input logic             arm,
  input logic             stop,
  input logic [CNT_W-1:0] cnt
);
  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !crst_evt) |=> $stable(cnt));

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == '0) && flag);

  // R3
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(ovf_evt));

  // R6
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(arm && flag_clr_wr));

  // R7
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && flag_clr_wr) |=> flag);

  // R5
  crst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crst_evt |=> (cnt == '0));

  // R2
  count_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> $past(tick || crst_evt));
endmodule

bind modtmr_top modtmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ovf_evt(ovf_evt), .crst_evt(crst_evt),
  .flag_clr_wr(flag_clr_wr), .flag(flag), .arm(arm), .stop(stop_q), .cnt(cnt)
);

// File: tb/modtmr_top_bench.sv
module modtmr_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  modtmr_top u_modtmr_top (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic read16(output int v);
    logic [7:0] h, l;
    rd(3'd1, h);
    rd(3'd2, l);
    v = {16'd0, h, l};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stop, clear counter, clear any pending flag, load modulo
  task automatic setup(input logic [2:0] sel, input logic [15:0] m);
    logic [7:0] s;
    rd(3'd0, s);
    wr(3'd0, 8'h30 | {5'd0, sel});
    wr(3'd3, m[15:8]);
    wr(3'd4, m[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, b;
    int v, d, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, s);  check("R1 status", s, 8'h20);
    read16(v);    check("R1 count", v, 0);
    rd(3'd3, b);  check("R1 modulo high", b, 8'hFF);
    rd(3'd4, b);  check("R1 modulo low", b, 8'hFF);
    check("R1 irq", irq, 0);
    idle(10);
    read16(v);    check("R1 held after reset", v, 0);

    // R2 prescaler sweep, modulo 5
    for (int sel = 0; sel < 8; sel++) begin
      d = (sel == 7) ? 64 : (1 << sel);
      k = 9 * d + d - 1;
      setup(sel[2:0], 16'd5);
      wr(3'd0, {5'd0, sel[2:0]});
      idle(k);
      read16(v);
      check($sformatf("R2 count sel=%0d", sel), v, (k / d) % 6);
      rd(3'd0, s);
      check($sformatf("R3 flag after wrap sel=%0d", sel), s[7], 1);
    end

    // R3 exact wrap edge, modulo 2, divide 1
    setup(3'd0, 16'd2);
    wr(3'd0, 8'h00);
    idle(2);
    rd(3'd0, s);  check("R3 flag clear before wrap", s[7], 0);
    rd(3'd0, s);  check("R3 flag set on wrap", s[7], 1);
    check("R9 irq masked", irq, 0);
    wr(3'd0, 8'hC0);
    rd(3'd0, s);  check("R8 write one keeps flag", s[7], 1);
    check("R9 irq enabled", irq, 1);

    // R7 overflow between arming read and clearing write
    rd(3'd0, s);
    idle(3);
    wr(3'd0, 8'h40);
    rd(3'd0, s);  check("R7 flag kept", s[7], 1);

    // R6 handshake, R8 write one with flag clear
    setup(3'd0, 16'd2);
    rd(3'd0, s);  check("R6 setup handshake cleared flag", s[7], 0);
    wr(3'd0, 8'h00);
    idle(3);
    wr(3'd0, 8'hA0);
    wr(3'd0, 8'h20);
    rd(3'd0, s);  check("R6 no clear without read", s[7], 1);
    wr(3'd0, 8'h20);
    rd(3'd0, s);  check("R6 clear after read", s[7], 0);
    wr(3'd0, 8'hA0);
    rd(3'd0, s);  check("R8 write one does not set", s[7], 0);

    // R4 stop and resume
    setup(3'd0, 16'hFFFF);
    wr(3'd0, 8'h00);
    idle(10);
    wr(3'd0, 8'h20);
    idle(5);
    read16(v);    check("R4 held while stopped", v, 11);
    wr(3'd0, 8'h00);
    idle(7);
    read16(v);    check("R4 resumed from held", v, 18);

    // R5 counter reset clears prescaler too
    setup(3'd2, 16'hFFFF);
    wr(3'd0, 8'h02);
    idle(6);
    wr(3'd0, 8'h12);
    idle(4);
    read16(v);    check("R5 count after reset", v, 1);
    rd(3'd0, s);  check("R5 reset bit reads zero", s, 8'h02);

    // R10 high-byte read latches low byte
    setup(3'd0, 16'hFFFF);
    wr(3'd0, 8'h00);
    idle(300);
    rd(3'd1, b);  check("R10 high byte", b, 8'h01);
    idle(3);
    rd(3'd2, b);  check("R10 latched low byte", b, 8'h2C);
    rd(3'd2, b);  check("R10 live low byte", b, 8'h31);

    // R11 zero modulo
    setup(3'd0, 16'h0000);
    wr(3'd0, 8'h00);
    idle(5);
    read16(v);    check("R11 count stays zero", v, 0);
    rd(3'd0, s);  check("R11 flag set", s[7], 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule